// File: doc/BRIEF.md
# Barrier Nap Controller

This controller sits beside one processor and takes over when that processor's thread arrives at a barrier. At arrival it receives a predicted stall time. It compares that time against the round-trip transition cost of each of three sleep depths. It then either keeps the thread spinning or requests the deepest depth whose cost still fits inside the prediction. For a depth that cannot snoop coherence traffic, it first asks the cache for a flush of dirty lines and waits for the acknowledgement.

While asleep, two wake sources race. The first is a local watchdog loaded with the predicted stall, which runs on a clock that keeps going during sleep. The second is a snoop comparator holding the barrier flag address, which fires when the releasing processor invalidates that line. Whichever source fires first ends the sleep. If the barrier is not yet released at that point, the controller spins residually until release and then departs. When the wake came from the invalidation, departure also reports how many cycles release preceded the wake, so a predictor can detect overprediction.

Top module: `barrier_nap_ctrl`

## Requirements
- R1: After reset, sleep_req_o, flush_req_o, snoop_arm_o, wake_o, depart_o and late_valid_o are all 0.
- R2: If pred_valid_i is low at arrival, or the predicted stall is below every depth's cost, the controller spins. sleep_req_o stays 0 and no wake strobe occurs. depart_o pulses in the cycle after the first cycle in which released_i is seen high.
- R3: Otherwise it selects the deepest depth k (1, 2 or 3) whose cost_sk_i is less than or equal to the predicted stall. sleep_req_o carries k (encoding 0 = awake, 1 = shallowest, 3 = deepest) for every cycle of sleep.
- R4: The watchdog is loaded with the prediction P at the arrival edge and counts down once per cycle while flushing or asleep. Counting the cycle right after the arrival edge as cycle 1, an unhindered sleep ends with wake_o high and wake_src_o = 0 in cycle P+1.
- R5: Throughout flushing and sleep, snoop_arm_o is high and snoop_addr_o holds the flag address captured at arrival. An invalidation whose address equals it ends sleep in the same cycle with wake_src_o = 1. An invalidation to any other address has no effect.
- R6: Wake is hybrid. Sleep ends in the earlier of the two source cycles, and when both fall in the same cycle wake_src_o is 1. wake_o is a single-cycle strobe.
- R7: For a depth marked non-snooping in NOSNOOP_MASK (bit k-1 for depth k), flush_req_o is held high from cycle 1 with sleep_req_o at 0 until flush_ack_i is seen. Sleep starts in the following cycle. A matching invalidation during the flush is remembered and ends sleep in its first cycle.
- R8: If released_i is low in the wake cycle, the controller spins residually and departs in the cycle after the first cycle in which released_i is seen high. If released_i is high in the wake cycle, it departs in the next cycle.
- R9: On departure after an external wake, late_valid_o pulses with depart_o. late_cycles_o then equals the number of flushing or sleeping cycles before the wake cycle in which released_i was high. After an internal wake late_valid_o stays 0.
- R10: arrive_i is ignored in every state except idle, including the departure cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, running during sleep |
| rst_n | input | 1 | Active-low asynchronous reset |
| arrive_i | input | 1 | Thread arrival strobe |
| pred_stall_i | input | STALL_W | Predicted stall in cycles |
| pred_valid_i | input | 1 | Prediction usable |
| flag_addr_i | input | ADDR_W | Barrier flag line address |
| cost_s1_i | input | STALL_W | Round-trip cost of depth 1 |
| cost_s2_i | input | STALL_W | Round-trip cost of depth 2 |
| cost_s3_i | input | STALL_W | Round-trip cost of depth 3 |
| inv_valid_i | input | 1 | Invalidation snoop valid |
| inv_addr_i | input | ADDR_W | Invalidation snoop address |
| flush_ack_i | input | 1 | Flush complete |
| released_i | input | 1 | Barrier release status level |
| flush_req_o | output | 1 | Flush request |
| snoop_arm_o | output | 1 | Snoop comparator armed |
| snoop_addr_o | output | ADDR_W | Address handed to snoop logic |
| sleep_req_o | output | 2 | Requested sleep depth, 0 = awake |
| wake_o | output | 1 | Wake strobe |
| wake_src_o | output | 1 | 1 = invalidation, 0 = watchdog |
| depart_o | output | 1 | Departure strobe |
| late_valid_o | output | 1 | Lateness report valid |
| late_cycles_o | output | LAT_W | Cycles between release and wake |

## Verification
The bench builds the controller with 12-bit stalls and costs of 4, 10 and 20 cycles, and marks only depth 3 as non-snooping. With these values, predictions drawn from 0 to 70 land in every depth and in the no-fit band, and the exact cost boundaries can be hit directly. Every depth-3 case exercises the flush handshake, with acknowledgement delays of several cycles that let invalidations fall inside the flush. Release and invalidation times drawn up to 80 cycles place the external wake before, at and after watchdog expiry, which covers residual spin and non-zero lateness.

// File: rtl/nap_pkg.sv
package nap_pkg;
  localparam int NUM_DEPTHS = 3;
  localparam int DEPTH_W    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPIN,
    ST_FLUSH,
    ST_SLEEP,
    ST_RESID,
    ST_DEPART
  } nap_state_e;

  // Deepest depth whose round-trip cost fits inside the stall; 0 when none.
  function automatic logic [DEPTH_W-1:0] deepest_fit(
    input logic [NUM_DEPTHS-1:0] fits
  );
    logic [DEPTH_W-1:0] d;
    d = '0;
    for (int k = 0; k < NUM_DEPTHS; k++)
      if (fits[k]) d = DEPTH_W'(k + 1);
    return d;
  endfunction

  // Increment that sticks at the all-ones value.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] max);
    return (v >= max) ? max : v + 32'd1;
  endfunction
endpackage

// File: rtl/nap_depth_pick.sv
module nap_depth_pick
  import nap_pkg::*;
#(
  parameter int STALL_W = 16
) (
  input  logic [STALL_W-1:0]                 stall_i,
  input  logic                               valid_i,
  input  logic [NUM_DEPTHS-1:0][STALL_W-1:0] cost_i,
  output logic [DEPTH_W-1:0]                 depth_o
);
  logic [NUM_DEPTHS-1:0] fits;

  for (genvar k = 0; k < NUM_DEPTHS; k++) begin : g_fit
    assign fits[k] = valid_i && (cost_i[k] <= stall_i);
  end

  assign depth_o = deepest_fit(fits);
endmodule

// File: rtl/nap_watchdog.sv
module nap_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/nap_flag_snoop.sv
module nap_flag_snoop #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic              armed_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              hit_now_o,
  output logic              hit_seen_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              seen_q;

  assign hit_now_o = armed_i && inv_valid_i && (inv_addr_i == addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      seen_q <= 1'b0;
    end else if (capture_i) begin
      addr_q <= cap_addr_i;
      seen_q <= 1'b0;
    end else if (hit_now_o) begin
      seen_q <= 1'b1;
    end
  end

  assign hit_seen_o = seen_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/nap_late_meter.sv
module nap_late_meter
  import nap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         count_i,
  output logic [W-1:0] value_o
);
  localparam logic [31:0] MAX_V = 32'((64'd1 << W) - 64'd1);
  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        val_q <= '0;
    else if (clear_i)  val_q <= '0;
    else if (count_i)  val_q <= W'(sat_inc(32'(val_q), MAX_V));
  end

  assign value_o = val_q;
endmodule

// File: rtl/barrier_nap_ctrl.sv
module barrier_nap_ctrl
  import nap_pkg::*;
#(
  parameter int                    STALL_W      = 16,
  parameter int                    ADDR_W       = 32,
  parameter int                    LAT_W        = 16,
  parameter logic [NUM_DEPTHS-1:0] NOSNOOP_MASK = 3'b100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arrive_i,
  input  logic [STALL_W-1:0] pred_stall_i,
  input  logic               pred_valid_i,
  input  logic [ADDR_W-1:0]  flag_addr_i,
  input  logic [STALL_W-1:0] cost_s1_i,
  input  logic [STALL_W-1:0] cost_s2_i,
  input  logic [STALL_W-1:0] cost_s3_i,
  input  logic               inv_valid_i,
  input  logic [ADDR_W-1:0]  inv_addr_i,
  input  logic               flush_ack_i,
  input  logic               released_i,
  output logic               flush_req_o,
  output logic               snoop_arm_o,
  output logic [ADDR_W-1:0]  snoop_addr_o,
  output logic [1:0]         sleep_req_o,
  output logic               wake_o,
  output logic               wake_src_o,
  output logic               depart_o,
  output logic               late_valid_o,
  output logic [LAT_W-1:0]   late_cycles_o
);
  nap_state_e state_q, state_d;
  logic [DEPTH_W-1:0] depth_q, depth_w;
  logic               ext_q;

  // Named internal events
  logic accept_w;
  logic asleep_w;
  logic armed_w;
  logic wd_expired_w;
  logic hit_now_w, hit_seen_w;
  logic wake_cond_w, wake_ext_w;
  logic needs_flush_w;

  logic [NUM_DEPTHS-1:0][STALL_W-1:0] costs;
  assign costs[0] = cost_s1_i;
  assign costs[1] = cost_s2_i;
  assign costs[2] = cost_s3_i;

  nap_depth_pick #(.STALL_W(STALL_W)) u_pick (
    .stall_i (pred_stall_i),
    .valid_i (pred_valid_i),
    .cost_i  (costs),
    .depth_o (depth_w)
  );

  assign accept_w = (state_q == ST_IDLE) && arrive_i;
  assign asleep_w = (state_q == ST_SLEEP);
  assign armed_w  = (state_q == ST_FLUSH) || asleep_w;

  always_comb begin
    needs_flush_w = 1'b0;
    for (int k = 0; k < NUM_DEPTHS; k++)
      if (depth_w == DEPTH_W'(k + 1)) needs_flush_w = NOSNOOP_MASK[k];
  end

  nap_watchdog #(.W(STALL_W)) u_wd (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept_w),
    .load_val_i (pred_stall_i),
    .run_i      (armed_w),
    .expired_o  (wd_expired_w)
  );

  nap_flag_snoop #(.ADDR_W(ADDR_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (accept_w),
    .cap_addr_i  (flag_addr_i),
    .armed_i     (armed_w),
    .inv_valid_i (inv_valid_i),
    .inv_addr_i  (inv_addr_i),
    .hit_now_o   (hit_now_w),
    .hit_seen_o  (hit_seen_w),
    .addr_o      (snoop_addr_o)
  );

  assign wake_ext_w  = asleep_w && (hit_now_w || hit_seen_w);
  assign wake_cond_w = wake_ext_w || (asleep_w && wd_expired_w);

  nap_late_meter #(.W(LAT_W)) u_late (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept_w),
    .count_i (armed_w && released_i && !wake_cond_w),
    .value_o (late_cycles_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (arrive_i) begin
          if (depth_w == '0)      state_d = ST_SPIN;
          else if (needs_flush_w) state_d = ST_FLUSH;
          else                    state_d = ST_SLEEP;
        end
      ST_SPIN:   if (released_i) state_d = ST_DEPART;
      ST_FLUSH:  if (flush_ack_i) state_d = ST_SLEEP;
      ST_SLEEP:
        if (wake_cond_w) state_d = released_i ? ST_DEPART : ST_RESID;
      ST_RESID:  if (released_i) state_d = ST_DEPART;
      ST_DEPART: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      depth_q <= '0;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        depth_q <= depth_w;
        ext_q   <= 1'b0;
      end else if (wake_cond_w) begin
        ext_q   <= wake_ext_w;
      end
    end
  end

  assign flush_req_o  = (state_q == ST_FLUSH);
  assign snoop_arm_o  = armed_w;
  assign sleep_req_o  = asleep_w ? depth_q : '0;
  assign wake_o       = wake_cond_w;
  assign wake_src_o   = wake_ext_w;
  assign depart_o     = (state_q == ST_DEPART);
  assign late_valid_o = depart_o && ext_q;
endmodule

// File: rtl/nap_ctrl_checker.sv
module nap_ctrl_checker #(
  parameter int         ADDR_W       = 32,
  parameter logic [2:0] NOSNOOP_MASK = 3'b100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              released_i,
  input logic              flush_ack_i,
  input logic              flush_req_o,
  input logic              snoop_arm_o,
  input logic [ADDR_W-1:0] snoop_addr_o,
  input logic [1:0]        sleep_req_o,
  input logic              wake_o,
  input logic              depart_o,
  input logic              late_valid_o,
  input logic              wd_expired
);
  logic nosnoop_now;
  always_comb begin
    case (sleep_req_o)
      2'd1:    nosnoop_now = NOSNOOP_MASK[0];
      2'd2:    nosnoop_now = NOSNOOP_MASK[1];
      2'd3:    nosnoop_now = NOSNOOP_MASK[2];
      default: nosnoop_now = 1'b0;
    endcase
  end

  AST_WAKE_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (sleep_req_o != 2'd0)); // R4
  AST_WD_EXPIRY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req_o != 2'd0 && wd_expired) |-> wake_o); // R4
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> (!wake_o && sleep_req_o == 2'd0)); // R6
  AST_SNOOP_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_arm_o && $past(snoop_arm_o)) |-> $stable(snoop_addr_o)); // R5
  AST_NOSNOOP_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    (nosnoop_now && $past(sleep_req_o) == 2'd0) |-> $past(flush_req_o && flush_ack_i)); // R7
  AST_DEPART_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    depart_o |-> $past(released_i)); // R8
  AST_LATE_WITH_DEPART: assert property (@(posedge clk) disable iff (!rst_n)
    late_valid_o |-> depart_o); // R9
  AST_EXCLUSIVE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_o, depart_o, flush_req_o})); // R6
endmodule

bind barrier_nap_ctrl nap_ctrl_checker #(
  .ADDR_W       (ADDR_W),
  .NOSNOOP_MASK (NOSNOOP_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .released_i   (released_i),
  .flush_ack_i  (flush_ack_i),
  .flush_req_o  (flush_req_o),
  .snoop_arm_o  (snoop_arm_o),
  .snoop_addr_o (snoop_addr_o),
  .sleep_req_o  (sleep_req_o),
  .wake_o       (wake_o),
  .depart_o     (depart_o),
  .late_valid_o (late_valid_o),
  .wd_expired   (wd_expired_w)
);

// File: tb/barrier_nap_ctrl_bench.sv
module barrier_nap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STALL_W = 12;
  localparam int ADDR_W  = 16;
  localparam int LAT_W   = 8;
  localparam int C1 = 4, C2 = 10, C3 = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arrive_i = 0, pred_valid_i = 0, inv_valid_i = 0, flush_ack_i = 0, released_i = 0;
  logic [STALL_W-1:0] pred_stall_i = '0;
  logic [ADDR_W-1:0]  flag_addr_i = '0, inv_addr_i = '0;
  logic flush_req_o, snoop_arm_o, wake_o, wake_src_o, depart_o, late_valid_o;
  logic [ADDR_W-1:0] snoop_addr_o;
  logic [1:0] sleep_req_o;
  logic [LAT_W-1:0] late_cycles_o;

  int n_checks = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrier_nap_ctrl #(
    .STALL_W(STALL_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W), .NOSNOOP_MASK(3'b100)
  ) u_barrier_nap_ctrl (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive_i), .pred_stall_i(pred_stall_i),
    .pred_valid_i(pred_valid_i), .flag_addr_i(flag_addr_i),
    .cost_s1_i(STALL_W'(C1)), .cost_s2_i(STALL_W'(C2)), .cost_s3_i(STALL_W'(C3)),
    .inv_valid_i(inv_valid_i), .inv_addr_i(inv_addr_i), .flush_ack_i(flush_ack_i),
    .released_i(released_i), .flush_req_o(flush_req_o), .snoop_arm_o(snoop_arm_o),
    .snoop_addr_o(snoop_addr_o), .sleep_req_o(sleep_req_o), .wake_o(wake_o),
    .wake_src_o(wake_src_o), .depart_o(depart_o), .late_valid_o(late_valid_o),
    .late_cycles_o(late_cycles_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of depth choice, written from the shallow end upward.
  function automatic int exp_depth(input int p, input bit v);
    if (!v || p < C1) return 0;
    if (p < C2) return 1;
    if (p < C3) return 2;
    return 3;
  endfunction

  function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction

  // p: prediction, v: valid, x: invalidation cycle (0 none), good: address matches,
  // r: first released cycle, a: flush ack cycle, stray: extra arrival at cycle 2
  task automatic run_case(input int p, input bit v, input int x, input bit good,
                          input int r, input int a, input bit stray);
    int d, ack, xe, w, dep, late, sleep_start, sleep_val, wake_at, src, dep_at;
    int lv, lc, flush_cyc, deps;
    bit ext;
    logic [ADDR_W-1:0] fa;
    fa = ADDR_W'($urandom);
    d = exp_depth(p, v);
    ack = (d == 3) ? a : 0;
    xe = (x != 0 && good) ? x : 1000000;
    w = imax(ack + 1, imin(p + 1, xe));
    ext = (xe <= w);
    dep = (d == 0) ? r + 1 : imax(w, r) + 1;
    late = (r < w) ? w - r : 0;
    sleep_start = 0; sleep_val = 0; wake_at = 0; src = 0; dep_at = 0;
    lv = 0; lc = 0; flush_cyc = 0; deps = 0;
    @(negedge clk);
    pred_stall_i = STALL_W'(p); pred_valid_i = v; flag_addr_i = fa; arrive_i = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= dep + 3; n++) begin
      @(negedge clk);
      arrive_i     = (stray && n == 2);
      pred_stall_i = stray ? STALL_W'(p + 7) : pred_stall_i;
      released_i   = (n >= r);
      inv_valid_i  = (n == x);
      inv_addr_i   = good ? fa : ~fa;
      flush_ack_i  = (n >= a);
      #1;
      if (flush_req_o) flush_cyc++;
      if (flush_req_o && sleep_req_o != 0) check(0, "R7 sleep during flush", sleep_req_o, 0);
      if (sleep_req_o != 0 && sleep_start == 0) begin sleep_start = n; sleep_val = sleep_req_o; end
      if (wake_o && wake_at == 0) begin wake_at = n; src = wake_src_o; end
      if (depart_o) begin
        deps++;
        if (dep_at == 0) begin dep_at = n; lv = late_valid_o; lc = late_cycles_o; end
      end
    end
    arrive_i = 0; inv_valid_i = 0; released_i = 0; flush_ack_i = 0;
    if (d == 0) begin
      check(sleep_start == 0, "R2 no sleep", sleep_val, 0);
      check(wake_at == 0, "R2 no wake", wake_at, 0);
    end else begin
      check(sleep_val == d, "R3 depth", sleep_val, d);
      check(sleep_start == ack + 1, "R7 sleep start", sleep_start, ack + 1);
      if (d == 3) check(flush_cyc == ack, "R7 flush length", flush_cyc, ack);
      else        check(flush_cyc == 0, "R7 no flush", flush_cyc, 0);
      check(wake_at == w, ext ? "R5 wake cycle" : "R4 wake cycle", wake_at, w);
      check(src == int'(ext), "R6 wake source", src, int'(ext));
      check(lv == int'(ext), "R9 late valid", lv, int'(ext));
      if (ext) check(lc == imin(late, 255), "R9 late cycles", lc, late);
    end
    check(dep_at == dep, "R8 depart cycle", dep_at, dep);
    check(deps == 1, "R10 single departure", deps, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    #1;
    check(sleep_req_o == 0 && !flush_req_o && !snoop_arm_o, "R1 reset outputs", sleep_req_o, 0);
    check(!wake_o && !depart_o && !late_valid_o, "R1 reset strobes", depart_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Directed corners
    run_case(50, 0, 0, 1, 5, 1, 0);     // R2 invalid prediction
    run_case(3, 1, 0, 1, 4, 1, 0);      // R2 below shallowest cost
    run_case(4, 1, 0, 1, 9, 1, 0);      // R3 exact fit depth 1, R4 watchdog
    run_case(9, 1, 0, 1, 3, 1, 0);      // R3 depth 1 upper edge, R8 release early
    run_case(10, 1, 6, 1, 6, 1, 0);     // R3 depth 2, R5 external wake
    run_case(15, 1, 16, 1, 16, 1, 0);   // R6 tie goes external
    run_case(15, 1, 8, 0, 30, 1, 0);    // R5 wrong address ignored, R8 residual spin
    run_case(20, 1, 0, 1, 40, 6, 0);    // R7 flush then depth 3
    run_case(25, 1, 3, 1, 2, 7, 0);     // R7 invalidation during flush, R9 late
    run_case(30, 1, 12, 1, 5, 2, 1);    // R10 stray arrival, R9 lateness
    // Random mix
    for (int i = 0; i < 40; i++) begin
      int p, x, r, a;
      bit v, g;
      p = int'($urandom_range(0, 70));
      v = ($urandom_range(0, 9) != 0);
      x = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 80));
      g = ($urandom_range(0, 4) != 0);
      r = int'($urandom_range(1, 80));
      a = int'($urandom_range(1, 10));
      run_case(p, v, x, g, r, a, $urandom_range(0, 3) == 0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule